// File: doc/BRIEF.md
# Key-Code Protected Configuration Commit

This block holds a small set of safety-related control bits that software can change only in two steps. First, software writes the new values into a staging register. The staged values have no effect on their own. Second, software writes a field-specific unlock code to a write-only command register. Each code copies only its own field from the staging register into the active copy. A read-only status register shows the active copies. The external-reset-disable bit keeps its active value through a system reset, and only power-on reset clears it.

The block also records reset causes. A sticky flag is set for each of six reset-event inputs. Software clears the flags the same protected way: it stages a clear request, then writes the clear code. All access goes through a byte-wide register bus. A write takes effect on the clock edge where `busWe` is high. The read data is combinational from the address, so a read in the next cycle already returns the new value.

Register map:

| Address | Register | Contents |
|---|---|---|
| 0 | Staging | bit 0 staged disable; bits 2:1 staged vector/area select |
| 1 | Command | write-only |
| 2 | Status | bit 0 active disable; bits 2:1 active select |
| 3 | Cause | bits 5:0 flags; bit 7 staged clear request |

Top module: `cfg_commit_guard`

## Requirements
- R1: After power-on reset, every register reads 0x00.
- R2: At address 0, bits 2:0 can be written and read back, and bits 7:3 read as zero. Writing the staging register alone leaves the status register at address 2 unchanged.
- R3: Writing 0xB2 to address 1 copies staged bit 0 into status bit 0. The next cycle's read shows the new value, and status bits 2:1 do not change.
- R4: Writing 0xD4 to address 1 copies staged bits 2:1 into status bits 2:1 together, and status bit 0 does not change.
- R5: Any other value written to address 1 changes neither the status register nor the cause flags.
- R6: Address 1 always reads 0x00.
- R7: While `sysRstN` is low, the following are cleared: the staging register, status bits 2:1 and the staged clear request. Status bit 0 and the cause flags are kept. Power-on reset clears all of them. Bus writes during either reset are ignored.
- R8: Cause flags sit at address 3, bits 5:0, in this order: watchdog, system, low-voltage 1, low-voltage 2, trimming, flash. A one-cycle pulse on `rstEvt[i]` sets flag i. The flag stays set until a committed clear, and it survives a system reset.
- R9: Writing 0x71 to address 1 while the staged clear request (address 3, bit 7) is 1 clears all flags and the request on that edge. If an event arrives on the same edge, it sets its flag anyway. Writing 0x71 while the request is 0 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| sysRstN | input | 1 | System reset, active low, synchronous |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write enable |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| rstEvt | input | 6 | Reset-cause event pulses, one per flag |

## Verification
The assertions assume the following about the inputs:
- Both resets are synchronous and change only between clock edges.
- `rstEvt` pulses are already in the clock domain.
- At most one command strobe is decoded per cycle.

The stimulus keeps within these limits as follows. It drives every bus, event and reset input on the falling edge. It issues one bus write at a time. It raises event pulses alone or together with a single clear commit, to cover the case where an event and a clear land on the same edge.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int VEC_W    = 2;
  localparam int CAUSE_N  = 6;
  localparam int STG_W    = VEC_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_STAGE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE  = 2'd3;

  localparam logic [DATA_W-1:0] KEY_DIS = 8'hB2;
  localparam logic [DATA_W-1:0] KEY_VEC = 8'hD4;
  localparam logic [DATA_W-1:0] KEY_CLR = 8'h71;

  typedef struct packed {
    logic             stageWr;
    logic             clrReqWr;
    logic             commitDis;
    logic             commitVec;
    logic             commitClr;
    logic [STG_W-1:0] stageData;
    logic             clrReqData;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
  import cfg_commit_pkg::*;
#(
  parameter logic [DATA_W-1:0] KeyDis = KEY_DIS,
  parameter logic [DATA_W-1:0] KeyVec = KEY_VEC,
  parameter logic [DATA_W-1:0] KeyClr = KEY_CLR
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output cfgStrobe_t        stb
);
  logic wrOk;
  logic cmdHit;

  assign wrOk   = busWe && porRstN && sysRstN;
  assign cmdHit = wrOk && (busAddr == ADDR_CMD);

  always_comb begin
    stb            = '0;
    stb.stageData  = busWdata[STG_W-1:0];
    stb.clrReqData = busWdata[DATA_W-1];
    stb.stageWr    = wrOk && (busAddr == ADDR_STAGE);
    stb.clrReqWr   = wrOk && (busAddr == ADDR_CAUSE);
    stb.commitDis  = cmdHit && (busWdata == KeyDis);
    stb.commitVec  = cmdHit && (busWdata == KeyVec);
    stb.commitClr  = cmdHit && (busWdata == KeyClr);
  end

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({stb.commitDis, stb.commitVec, stb.commitClr}));

  // R7
  no_wr_in_rst_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |-> !(stb.stageWr || stb.clrReqWr || stb.commitDis || stb.commitVec || stb.commitClr));
endmodule

// File: rtl/cfg_commit_dp.sv
module cfg_commit_dp
  import cfg_commit_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  cfgStrobe_t         stb,
  input  logic [CAUSE_N-1:0] rstEvt,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busRdata
);
  logic [STG_W-1:0]   stageQ;
  logic               actDisQ;
  logic [VEC_W-1:0]   actVecQ;
  logic               clrReqQ;
  logic [CAUSE_N-1:0] causeQ;
  logic               clrFire;

  assign clrFire = stb.commitClr && clrReqQ;

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) stageQ <= '0;
    else if (stb.stageWr)     stageQ <= stb.stageData;
  end

  always_ff @(posedge clk) begin
    if (!porRstN)           actDisQ <= 1'b0;
    else if (stb.commitDis) actDisQ <= stageQ[0];
  end

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) actVecQ <= '0;
    else if (stb.commitVec)   actVecQ <= stageQ[STG_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) clrReqQ <= 1'b0;
    else if (stb.commitClr)   clrReqQ <= 1'b0;
    else if (stb.clrReqWr)    clrReqQ <= stb.clrReqData;
  end

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!porRstN)       causeQ[i] <= 1'b0;
      else if (rstEvt[i]) causeQ[i] <= 1'b1;
      else if (clrFire)   causeQ[i] <= 1'b0;
    end

    // R8
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!porRstN)
      rstEvt[i] |=> causeQ[i]);

    // R9
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!porRstN)
      (stb.commitClr && clrReqQ && !rstEvt[i]) |=> !causeQ[i]);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_STAGE:  busRdata[STG_W-1:0] = stageQ;
      ADDR_STATUS: busRdata[STG_W-1:0] = {actVecQ, actDisQ};
      ADDR_CAUSE: begin
        busRdata[CAUSE_N-1:0] = causeQ;
        busRdata[DATA_W-1]    = clrReqQ;
      end
      default:     busRdata = '0;
    endcase
  end

  // R3
  dis_commit_chk: assert property (@(posedge clk) disable iff (!porRstN)
    stb.commitDis |=> actDisQ == $past(stageQ[0]));

  // R4
  vec_commit_chk: assert property (@(posedge clk) disable iff (!porRstN)
    stb.commitVec |=> actVecQ == $past(stageQ[STG_W-1:1]));

  // R7
  dis_keeps_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> $stable(actDisQ));

  // R7
  stage_clears_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> (stageQ == '0 && actVecQ == '0));
endmodule

// File: rtl/cfg_commit_guard.sv
module cfg_commit_guard
  import cfg_commit_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [CAUSE_N-1:0] rstEvt
);
  cfgStrobe_t stb;

  cfg_commit_ctrl ctrl_i (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .stb      (stb)
  );

  cfg_commit_dp dp_i (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .stb      (stb),
    .rstEvt   (rstEvt),
    .busAddr  (busAddr),
    .busRdata (busRdata)
  );

  // R6
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (busAddr == ADDR_CMD) |-> (busRdata == '0));
endmodule

// File: tb/cfg_commit_guard_tb.sv
module cfg_commit_guard_tb_top;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       sysRstN = 1'b1;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic [5:0] rstEvt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  cfg_commit_guard dut_i (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata), .rstEvt(rstEvt)
  );

  // monitor: compares the read data against the scoreboard head
  initial begin
    forever begin
      wait (sbQ.size() != 0);
      #1;
      checks++;
      if (busRdata !== sbQ[0].exp) begin
        errors++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", sbQ[0].tag, busRdata, sbQ[0].exp);
      end
      void'(sbQ.pop_front());
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic [5:0] e = '0);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; rstEvt = e;
    @(negedge clk);
    busWe = 1'b0; rstEvt = '0;
  endtask

  task automatic pulseEvt(input logic [5:0] e);
    @(negedge clk);
    rstEvt = e;
    @(negedge clk);
    rstEvt = '0;
  endtask

  task automatic expectRd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic sysPulse();
    @(negedge clk); sysRstN = 1'b0;
    @(negedge clk); @(negedge clk); sysRstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) expectRd(a[1:0], 8'h00, "R1 reset");
    // R2 staging width and inertness
    busWrite(2'd0, 8'hFF);
    expectRd(2'd0, 8'h07, "R2 stage readback");
    expectRd(2'd2, 8'h00, "R2 stage inert");
    // R5 wrong codes
    busWrite(2'd1, 8'h55);
    busWrite(2'd1, 8'hB3);
    expectRd(2'd2, 8'h00, "R5 bad code");
    // R3 disable commit
    busWrite(2'd1, 8'hB2);
    expectRd(2'd2, 8'h01, "R3 dis commit");
    // R4 vector commit
    busWrite(2'd1, 8'hD4);
    expectRd(2'd2, 8'h07, "R4 vec commit");
    busWrite(2'd0, 8'h04);
    busWrite(2'd1, 8'hD4);
    expectRd(2'd2, 8'h05, "R4 vec only");
    // R6 command reads zero
    expectRd(2'd1, 8'h00, "R6 cmd read");
    // R7 system reset
    sysPulse();
    expectRd(2'd0, 8'h00, "R7 stage cleared");
    expectRd(2'd2, 8'h01, "R7 dis kept");
    // R8 flags
    pulseEvt(6'h01);
    expectRd(2'd3, 8'h01, "R8 watchdog flag");
    pulseEvt(6'h28);
    expectRd(2'd3, 8'h29, "R8 sticky flags");
    // R9 clear without request
    busWrite(2'd1, 8'h71);
    expectRd(2'd3, 8'h29, "R9 no request");
    busWrite(2'd3, 8'h80);
    expectRd(2'd3, 8'hA9, "R9 request staged");
    busWrite(2'd1, 8'h72);
    expectRd(2'd3, 8'hA9, "R5 bad clear code");
    busWrite(2'd1, 8'h71);
    expectRd(2'd3, 8'h00, "R9 cleared");
    // R9 event wins
    pulseEvt(6'h04);
    busWrite(2'd3, 8'h80);
    busWrite(2'd1, 8'h71, 6'h10);
    expectRd(2'd3, 8'h10, "R9 event wins");
    // R8 flags survive system reset; R7 request and writes during reset
    busWrite(2'd3, 8'h80);
    sysPulse();
    expectRd(2'd3, 8'h10, "R8 survive sysrst");
    @(negedge clk); sysRstN = 1'b0;
    busWrite(2'd0, 8'h07);
    busWrite(2'd1, 8'hB2);
    @(negedge clk); sysRstN = 1'b1;
    expectRd(2'd0, 8'h00, "R7 write in reset");
    expectRd(2'd2, 8'h01, "R7 commit in reset");
    // R7 power-on reset clears all
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    expectRd(2'd2, 8'h00, "R7 por status");
    expectRd(2'd3, 8'h00, "R7 por cause");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule